// File: doc/BRIEF.md
# Execute-in-place serial flash read port

This block lets a processor fetch 32-bit words from a serial NOR flash as if the flash were memory. When reset is released it sets up the flash by itself over a single-bit serial link. It first sends a write-enable transaction. It then sends a volatile-configuration write that selects four dummy clocks, turns on execute-in-place operation and sets the wrap control. While this setup runs, the busy output stays high.

The processor asks for a word by pulsing a read strobe together with a word address, and waits until busy falls. The first read after setup is a full fast-read transaction carrying its opcode, and that transaction places the flash in execute-in-place mode. Every later read sends only the 24-bit address, followed by the dummy clocks and the 32 data clocks, so each of those reads saves eight flash clocks.

The flash clock is the inverted system clock, gated by chip select. Outgoing bits change just after each rising system edge. Incoming bits are captured on each rising system edge.

Top module: `xip_flash_reader`

## Requirements
- R1: While reset is high, and from reset release until setup completes, chip select is high outside transactions, the flash clock is low whenever chip select is high, and busy is high.
- R2: The first transaction after reset carries exactly 8 flash clocks with the byte 0x06, most significant bit first, inside its own chip-select low window.
- R3: The second transaction carries exactly 16 flash clocks: opcode 0x08, then the configuration byte. That byte holds the dummy count 4 in bits [7:4], a 1 in bit 3 (execute-in-place on), a 0 in bit 2, and 2'b11 in bits [1:0], which gives 0x4B.
- R4: Chip select stays high for at least one full system clock between any two transactions.
- R5: A read strobe that arrives during setup is held, with the most recent address winning, and is serviced as soon as setup ends. Busy does not fall between setup and the end of that read.
- R6: The first read is 68 flash clocks long: opcode 0x0B, 24 address bits, 4 dummy clocks and 32 data clocks.
- R7: Every later read is 60 flash clocks long: 24 address bits, 4 dummy clocks and 32 data clocks. Busy is high for 61 system cycles, counted from the edge that samples the strobe.
- R8: The flash byte address is {2'b00, word address[19:0], 2'b00}, sent most significant bit first.
- R9: Data bytes arrive least significant byte first, each byte most significant bit first. The returned word has the first byte in bits [7:0] and the last byte in bits [31:24], and it stays valid after busy falls.
- R10: The flash clock equals the inverted system clock while chip select is low and is low otherwise. MOSI is held low during the dummy and data clocks.
- R11: A read strobe given while a read is in progress is ignored. It starts no transaction and does not change the returned word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| rd_strobe_i | input | 1 | One-cycle read request |
| rd_addr_i | input | 20 | Word address of the request |
| rd_data_o | output | 32 | Word returned by the last completed read |
| busy_o | output | 1 | High during setup and during each read |
| flash_clk_o | output | 1 | Gated, inverted flash clock |
| flash_cs_n_o | output | 1 | Flash chip select, active low |
| flash_mosi_o | output | 1 | Serial data to the flash |
| flash_miso_i | input | 1 | Serial data from the flash |

## Verification
The bench builds the block with its default parameters: a 20-bit word address, a 24-bit flash address, 32-bit data, 4 dummy clocks and wrap code 2'b11. These values produce the 0x4B configuration byte and the 68- and 60-clock read frames that the flash model counts. The extreme word address 0xFFFFF drives the top address bits, and the model's distinct byte values per address expose any byte-order or address-packing mistake. The bench also places strobes inside the setup window and inside a running read, which exercises the held request and the ignore path.

// File: rtl/xipf_pkg.sv
package xipf_pkg;

    typedef enum logic [1:0] {
        ST_BOOT,
        ST_XFER,
        ST_GAP,
        ST_IDLE
    } seq_state_e;

    typedef enum logic [1:0] {
        TK_WREN,
        TK_CFG,
        TK_FIRST,
        TK_XIP
    } txn_kind_e;

    typedef enum logic [1:0] {
        PH_CMD,
        PH_WAIT,
        PH_DATA
    } xfer_phase_e;

    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_CFG  = 8'h08;
    localparam logic [7:0] OP_FAST = 8'h0B;

endpackage

// File: rtl/xipf_shift.sv
module xipf_shift #(
    parameter int FRAME_W = 32,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_i,
    input  logic               load_i,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic               tx_shift_i,
    input  logic               tx_en_i,
    input  logic               rx_shift_i,
    input  logic               rx_last_i,
    input  logic               cs_n_i,
    input  logic               miso_i,
    output logic               mosi_o,
    output logic [DATA_W-1:0]  rdata_o
);

    localparam int NBYTES = DATA_W / 8;

    typedef struct packed {
        logic [FRAME_W-1:0] tx;
        logic [DATA_W-1:0]  rx;
        logic [DATA_W-1:0]  word;
    } dp_t;

    dp_t dp_d, dp_q;

    logic [DATA_W-1:0] rx_next;
    logic [DATA_W-1:0] arrived;

    assign rx_next = {dp_q.rx[DATA_W-2:0], miso_i};

    // first received byte lands in the lowest lane
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        assign arrived[b*8 +: 8] = rx_next[(NBYTES-1-b)*8 +: 8];
    end

    always_comb begin
        dp_d = dp_q;
        if (load_i) begin
            dp_d.tx = frame_i;
        end else if (tx_shift_i) begin
            dp_d.tx = {dp_q.tx[FRAME_W-2:0], 1'b0};
        end
        if (rx_shift_i) begin
            dp_d.rx = rx_next;
            if (rx_last_i) begin
                dp_d.word = arrived;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst_i) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign mosi_o  = tx_en_i & dp_q.tx[FRAME_W-1];
    assign rdata_o = dp_q.word;

    // R4
    ld_gap_chk: assert property (@(posedge clk) disable iff (rst_i)
        load_i |-> cs_n_i);

    // R10
    rx_sel_chk: assert property (@(posedge clk) disable iff (rst_i)
        rx_shift_i |-> !cs_n_i);

endmodule

// File: rtl/xipf_ctrl.sv
module xipf_ctrl
    import xipf_pkg::*;
#(
    parameter int         WADDR_W    = 20,
    parameter int         FADDR_W    = 24,
    parameter int         DATA_W     = 32,
    parameter int         DUMMY_CLKS = 4,
    parameter logic [1:0] WRAP_MODE  = 2'b11,
    parameter int         FRAME_W    = 8 + FADDR_W
) (
    input  logic               clk,
    input  logic               rst_i,
    input  logic               rd_strobe_i,
    input  logic [WADDR_W-1:0] rd_addr_i,
    output logic               load_o,
    output logic [FRAME_W-1:0] frame_o,
    output logic               tx_shift_o,
    output logic               tx_en_o,
    output logic               rx_shift_o,
    output logic               rx_last_o,
    output logic               cs_n_o,
    output logic               busy_o
);

    localparam int MAXC  = (FRAME_W > DATA_W) ? FRAME_W : DATA_W;
    localparam int CNT_W = $clog2(MAXC + DUMMY_CLKS + 1);
    localparam logic [7:0] CFG_BYTE = {4'(DUMMY_CLKS), 1'b1, 1'b0, WRAP_MODE};

    typedef struct packed {
        seq_state_e         st;
        txn_kind_e          kind;
        xfer_phase_e        ph;
        logic [CNT_W-1:0]   cnt;
        logic               pend;
        logic [WADDR_W-1:0] paddr;
        logic               done;
        logic               xip;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic               start;
    txn_kind_e          start_kind;
    logic [WADDR_W-1:0] start_addr;

    function automatic logic [FADDR_W-1:0] byte_addr(input logic [WADDR_W-1:0] wa);
        logic [FADDR_W-1:0] ba;
        ba = '0;
        ba[WADDR_W+1:2] = wa;
        return ba;
    endfunction

    function automatic logic [FRAME_W-1:0] frame_for(input txn_kind_e k,
                                                     input logic [WADDR_W-1:0] wa);
        logic [FRAME_W-1:0] f;
        case (k)
            TK_WREN:  f = {OP_WREN, {FADDR_W{1'b0}}};
            TK_CFG:   f = {OP_CFG, CFG_BYTE, {(FADDR_W-8){1'b0}}};
            TK_FIRST: f = {OP_FAST, byte_addr(wa)};
            default:  f = {byte_addr(wa), 8'h00};
        endcase
        return f;
    endfunction

    function automatic logic [CNT_W-1:0] tx_bits(input txn_kind_e k);
        logic [CNT_W-1:0] n;
        case (k)
            TK_WREN:  n = CNT_W'(8);
            TK_CFG:   n = CNT_W'(16);
            TK_FIRST: n = CNT_W'(FRAME_W);
            default:  n = CNT_W'(FADDR_W);
        endcase
        return n;
    endfunction

    function automatic logic has_data(input txn_kind_e k);
        return (k == TK_FIRST) || (k == TK_XIP);
    endfunction

    always_comb begin
        ctl_d      = ctl_q;
        start      = 1'b0;
        start_kind = TK_XIP;
        start_addr = rd_addr_i;
        load_o     = 1'b0;
        frame_o    = '0;

        case (ctl_q.st)
            ST_BOOT: begin
                start      = 1'b1;
                start_kind = TK_WREN;
            end
            ST_XFER: begin
                ctl_d.cnt = ctl_q.cnt - CNT_W'(1);
                case (ctl_q.ph)
                    PH_CMD: begin
                        if (ctl_q.cnt == CNT_W'(1)) begin
                            if (!has_data(ctl_q.kind)) begin
                                ctl_d.st = ST_GAP;
                            end else if (DUMMY_CLKS > 0) begin
                                ctl_d.ph  = PH_WAIT;
                                ctl_d.cnt = CNT_W'(DUMMY_CLKS);
                            end else begin
                                ctl_d.ph  = PH_DATA;
                                ctl_d.cnt = CNT_W'(DATA_W);
                            end
                        end
                    end
                    PH_WAIT: begin
                        if (ctl_q.cnt == CNT_W'(1)) begin
                            ctl_d.ph  = PH_DATA;
                            ctl_d.cnt = CNT_W'(DATA_W);
                        end
                    end
                    default: begin
                        if (ctl_q.cnt == CNT_W'(1)) begin
                            ctl_d.st = ST_GAP;
                        end
                    end
                endcase
            end
            ST_GAP: begin
                case (ctl_q.kind)
                    TK_WREN: begin
                        start      = 1'b1;
                        start_kind = TK_CFG;
                    end
                    TK_CFG: begin
                        ctl_d.done = 1'b1;
                        if (ctl_q.pend || rd_strobe_i) begin
                            start      = 1'b1;
                            start_kind = TK_FIRST;
                            start_addr = rd_strobe_i ? rd_addr_i : ctl_q.paddr;
                            ctl_d.pend = 1'b0;
                        end else begin
                            ctl_d.st = ST_IDLE;
                        end
                    end
                    default: ctl_d.st = ST_IDLE;
                endcase
            end
            default: begin
                if (rd_strobe_i) begin
                    start      = 1'b1;
                    start_kind = ctl_q.xip ? TK_XIP : TK_FIRST;
                end
            end
        endcase

        // a request during setup is parked; the newest address replaces an older one
        if (!ctl_q.done && rd_strobe_i &&
            !(ctl_q.st == ST_GAP && ctl_q.kind == TK_CFG)) begin
            ctl_d.pend  = 1'b1;
            ctl_d.paddr = rd_addr_i;
        end

        if (start) begin
            ctl_d.st   = ST_XFER;
            ctl_d.kind = start_kind;
            ctl_d.ph   = PH_CMD;
            ctl_d.cnt  = tx_bits(start_kind);
            if (start_kind == TK_FIRST) begin
                ctl_d.xip = 1'b1;
            end
            load_o  = 1'b1;
            frame_o = frame_for(start_kind, start_addr);
        end
    end

    always_ff @(posedge clk) begin
        if (rst_i) begin
            ctl_q.st    <= ST_BOOT;
            ctl_q.kind  <= TK_WREN;
            ctl_q.ph    <= PH_CMD;
            ctl_q.cnt   <= '0;
            ctl_q.pend  <= 1'b0;
            ctl_q.paddr <= '0;
            ctl_q.done  <= 1'b0;
            ctl_q.xip   <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cs_n_o     = (ctl_q.st != ST_XFER);
    assign busy_o     = (ctl_q.st != ST_IDLE);
    assign tx_en_o    = (ctl_q.st == ST_XFER) && (ctl_q.ph == PH_CMD);
    assign tx_shift_o = tx_en_o;
    assign rx_shift_o = (ctl_q.st == ST_XFER) && (ctl_q.ph == PH_DATA);
    assign rx_last_o  = rx_shift_o && (ctl_q.cnt == CNT_W'(1));

    // R1
    setup_busy_chk: assert property (@(posedge clk) disable iff (rst_i)
        !ctl_q.done |-> busy_o);

    // R5
    pend_keep_chk: assert property (@(posedge clk) disable iff (rst_i)
        (ctl_q.pend && !ctl_q.done) |=> (ctl_q.pend || ctl_q.st == ST_XFER));

    // R3
    data_kind_chk: assert property (@(posedge clk) disable iff (rst_i)
        rx_shift_o |-> (ctl_q.kind == TK_FIRST || ctl_q.kind == TK_XIP));

    // R6
    xip_entry_chk: assert property (@(posedge clk) disable iff (rst_i)
        $rose(ctl_q.xip) |-> (ctl_q.st == ST_XFER && ctl_q.kind == TK_FIRST));

endmodule

// File: rtl/xip_flash_reader.sv
module xip_flash_reader #(
    parameter int         WADDR_W    = 20,
    parameter int         FADDR_W    = 24,
    parameter int         DATA_W     = 32,
    parameter int         DUMMY_CLKS = 4,
    parameter logic [1:0] WRAP_MODE  = 2'b11
) (
    input  logic               clk,
    input  logic               rst_i,
    input  logic               rd_strobe_i,
    input  logic [WADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0]  rd_data_o,
    output logic               busy_o,
    output logic               flash_clk_o,
    output logic               flash_cs_n_o,
    output logic               flash_mosi_o,
    input  logic               flash_miso_i
);

    localparam int FRAME_W = 8 + FADDR_W;

    logic               load;
    logic [FRAME_W-1:0] frame;
    logic               tx_shift;
    logic               tx_en;
    logic               rx_shift;
    logic               rx_last;
    logic               cs_n;

    xipf_ctrl #(
        .WADDR_W    (WADDR_W),
        .FADDR_W    (FADDR_W),
        .DATA_W     (DATA_W),
        .DUMMY_CLKS (DUMMY_CLKS),
        .WRAP_MODE  (WRAP_MODE),
        .FRAME_W    (FRAME_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_i       (rst_i),
        .rd_strobe_i (rd_strobe_i),
        .rd_addr_i   (rd_addr_i),
        .load_o      (load),
        .frame_o     (frame),
        .tx_shift_o  (tx_shift),
        .tx_en_o     (tx_en),
        .rx_shift_o  (rx_shift),
        .rx_last_o   (rx_last),
        .cs_n_o      (cs_n),
        .busy_o      (busy_o)
    );

    xipf_shift #(
        .FRAME_W (FRAME_W),
        .DATA_W  (DATA_W)
    ) u_shift (
        .clk        (clk),
        .rst_i      (rst_i),
        .load_i     (load),
        .frame_i    (frame),
        .tx_shift_i (tx_shift),
        .tx_en_i    (tx_en),
        .rx_shift_i (rx_shift),
        .rx_last_i  (rx_last),
        .cs_n_i     (cs_n),
        .miso_i     (flash_miso_i),
        .mosi_o     (flash_mosi_o),
        .rdata_o    (rd_data_o)
    );

    // flash samples MOSI on its rising edge, i.e. mid-cycle of the system clock
    assign flash_clk_o  = ~cs_n & ~clk;
    assign flash_cs_n_o = cs_n;

endmodule

// File: tb/tb_xip_flash_reader.sv
`timescale 1ns/1ps
module tb_xip_flash_reader;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_strobe = 1'b0;
    logic [19:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic        busy;
    logic        fclk;
    logic        cs_n;
    logic        mosi;
    logic        miso = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [31:0] word;
        int          len;
    } exp_t;

    exp_t exq[$];
    logic [19:0] last_wa = '0;

    always #10 clk = ~clk;

    xip_flash_reader dut (
        .clk          (clk),
        .rst_i        (rst),
        .rd_strobe_i  (rd_strobe),
        .rd_addr_i    (rd_addr),
        .rd_data_o    (rd_data),
        .busy_o       (busy),
        .flash_clk_o  (fclk),
        .flash_cs_n_o (cs_n),
        .flash_mosi_o (mosi),
        .flash_miso_i (miso)
    );

    function automatic logic [31:0] flash_word(input logic [23:0] a);
        return {a[7:0] ^ 8'h5A, a[23:16] ^ 8'h3C, a[15:8] ^ 8'hC3, ~a[7:0]};
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // ---------------- behavioural flash ----------------
    int          m_txn = 0;
    int          m_edge = 0;
    logic [95:0] m_bits = '0;
    logic [7:0]  m_op = '0;
    logic [23:0] m_addr = '0;
    logic [31:0] m_word = '0;
    bit          m_bad = 0;

    always @(posedge fclk or posedge cs_n) begin
        if (cs_n) begin
            if (m_edge > 0) begin
                case (m_txn)
                    0: chk(m_edge == 8 && m_bits[7:0] == 8'h06, "R2",
                           {m_bits[23:0], 8'(m_edge)}, {24'h06, 8'd8});
                    1: chk(m_edge == 16 && m_bits[15:0] == 16'h084B, "R3",
                           {m_bits[23:0], 8'(m_edge)}, {24'h084B, 8'd16});
                    2: begin
                        chk(m_edge == 68 && m_op == 8'h0B, "R6",
                            {m_op, 24'(m_edge)}, {8'h0B, 24'd68});
                        chk(m_addr == {2'b00, last_wa, 2'b00}, "R8",
                            32'(m_addr), {8'h00, 2'b00, last_wa, 2'b00});
                        chk(!m_bad, "R10", 32'(m_bad), 32'd0);
                    end
                    default: begin
                        chk(m_edge == 60, "R7", m_edge, 32'd60);
                        chk(m_addr == {2'b00, last_wa, 2'b00}, "R8",
                            32'(m_addr), {8'h00, 2'b00, last_wa, 2'b00});
                        chk(!m_bad, "R10", 32'(m_bad), 32'd0);
                    end
                endcase
                m_txn++;
            end
            m_edge = 0;
            m_bits = '0;
            m_bad  = 0;
            miso   = 1'b0;
        end else begin
            int aend;
            int dstart;
            aend   = (m_txn == 2) ? 32 : 24;
            dstart = aend + 4;
            m_bits = {m_bits[94:0], mosi};
            if (m_edge == 7) m_op = m_bits[7:0];
            if (m_txn >= 2) begin
                if (m_edge == aend - 1) begin
                    m_addr = m_bits[23:0];
                    m_word = flash_word(m_addr);
                end
                if (m_edge >= aend && mosi) m_bad = 1;
                if (m_edge >= dstart && m_edge < dstart + 32) begin
                    int k;
                    k = m_edge - dstart;
                    miso = m_word[(k / 8) * 8 + 7 - (k % 8)];
                end
            end
            m_edge++;
        end
    end

    // ---------------- monitor / scoreboard ----------------
    logic prev_busy = 1'b1;
    logic prev_cs = 1'b1;
    int   bcnt = 0;
    int   hi_cnt = 1;
    bit   first_fall = 1;
    bit   clk_bad = 0;

    always @(negedge clk) begin
        if (!rst) begin
            exp_t e;
            if (cs_n && fclk) clk_bad = 1;
            if (!cs_n && !fclk) clk_bad = 1;
            if (prev_cs && !cs_n) chk(hi_cnt >= 1, "R4", hi_cnt, 32'd1);
            if (cs_n) hi_cnt++;
            else hi_cnt = 0;
            prev_cs = cs_n;
            if (busy) begin
                bcnt++;
            end else if (prev_busy) begin
                if (first_fall) begin
                    chk(exq.size() > 0, "R5", exq.size(), 32'd1);
                    first_fall = 0;
                end
                if (exq.size() > 0) begin
                    e = exq.pop_front();
                    chk(rd_data == e.word, "R9", rd_data, e.word);
                    if (e.len > 0) chk(bcnt == e.len, "R7", bcnt, e.len);
                end
                bcnt = 0;
            end
            prev_busy = busy;
        end
    end

    // ---------------- driver ----------------
    task automatic do_read(input logic [19:0] wa, input int len);
        exp_t e;
        @(negedge clk);
        e.word = flash_word({2'b00, wa, 2'b00});
        e.len  = len;
        exq.push_back(e);
        last_wa   = wa;
        rd_addr   = wa;
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    task automatic raw_strobe(input logic [19:0] wa);
        @(negedge clk);
        rd_addr   = wa;
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy);
    endtask

    initial begin
        bit stray;
        repeat (4) @(negedge clk);
        chk(cs_n == 1'b1, "R1", 32'(cs_n), 32'd1);
        chk(fclk == 1'b0, "R1", 32'(fclk), 32'd0);
        chk(busy == 1'b1, "R1", 32'(busy), 32'd1);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy == 1'b1, "R1", 32'(busy), 32'd1);

        // two requests during setup: the later one must be served (R5)
        raw_strobe(20'h00123);
        repeat (4) @(negedge clk);
        do_read(20'h00456, 0);
        wait_idle();

        do_read(20'h00000, 61);
        wait_idle();
        do_read(20'hFFFFF, 61);
        wait_idle();

        // R11: strobe inside a running read
        do_read(20'h0ABCD, 61);
        repeat (10) @(negedge clk);
        raw_strobe(20'h11111);
        wait_idle();
        stray = 0;
        repeat (5) begin
            @(negedge clk);
            if (busy || !cs_n) stray = 1;
        end
        chk(!stray, "R11", 32'(stray), 32'd0);

        for (int i = 0; i < 5; i++) begin
            do_read(20'h13579 + 20'(i) * 20'h0F0F1, 61);
            wait_idle();
        end

        repeat (3) @(negedge clk);
        chk(m_txn == 11, "R11", m_txn, 32'd11);
        chk(exq.size() == 0, "R9", exq.size(), 32'd0);
        chk(!clk_bad, "R10", 32'(clk_bad), 32'd0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R7: watchdog expired, actual busy %0d expected 0", busy);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule